// File: doc/BRIEF.md
# Galloping Pattern Memory Self-Test Controller

This block is a built-in self-test sequencer for a synchronous single-port RAM. After a start pulse it takes a contiguous address window, given by a base address and a cell count, and fills every cell of the window with a fixed background word. It then makes each cell of the window the probe cell in turn, one after another. For each probe cell it writes a probe value and then visits every other cell of the window. Each visit reads the other cell and expects the background. It then reads the probe cell again and expects the probe value. When the visits are finished, the probe cell gets the background word back.

The first full sweep uses the bitwise inverse of the background as the probe value. A second full sweep repeats the same order of accesses, but the probe value equals the background. This finds stuck bits, and it finds faults in which a write to one cell disturbs another cell. Each read is compared one cycle after its address is issued. The first mismatch ends the test at once, with fail raised and the failing address held. A clean run ends with done raised.

Top module: `galpat_bist`

## Requirements
- R1: After reset, busy, done and fail are 0 and ram_we is 0.
- R2: A run with count L>0 begins with L write cycles that store the background parameter BG (default all zeros) at offsets 0,1,…,L-1 from the base, in ascending order, one per cycle.
- R3: In each sweep, probe cells are taken at offsets 0 to L-1 in ascending order. Each probe cell starts with one write of its probe value, which is ~BG in the first sweep and BG in the second sweep.
- R4: After the probe write, for each other offset o in ascending order, the controller reads offset o (expecting BG) in one cycle and then reads the probe offset (expecting the probe value) in the next cycle.
- R5: After its last read pair, the probe cell is rewritten with BG before the next probe cell is written. A clean run therefore leaves every cell of the window holding BG.
- R6: A clean run keeps busy high for exactly L + 4·L² cycles. done then rises with busy low and fail low, and stays high until the next accepted start, which clears it.
- R7: RAM read data is valid one cycle after the read address. On the first mismatch, busy falls and fail rises two cycles after the read cycle. fail_addr holds the read address, no further RAM write occurs, and fail and fail_addr hold until the next start.
- R8: If the compare of the final read of the second sweep mismatches, fail is reported and done stays low.
- R9: A start with count 0 sets done in the next cycle with no RAM write and no busy cycle.
- R10: start while busy is ignored. The running test keeps its base, count and access order.
- R11: Every address issued while busy lies inside the window, computed as (base + offset) modulo the address space, so a window may wrap past the top address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a test when idle |
| base | input | AW | First address of the window |
| len | input | AW+1 | Number of cells in the window (0 to 2^AW) |
| ram_addr | output | AW | RAM address |
| ram_we | output | 1 | RAM write enable (a read when low) |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, one cycle after the address |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished with no mismatch |
| fail | output | 1 | Mismatch found |
| fail_addr | output | AW | Address of the first mismatching read |

## Verification
Completion and failure can meet in one cycle. The compare of the last probe read falls in the cycle that writes back the final probe cell, and that same cycle would otherwise end the run with done. The bench provokes this with a RAM model that corrupts exactly one numbered read, the last one of the run. It expects fail with that cell's address, done low, and a busy length equal to a full clean run. A second coincidence is a start pulse that arrives in the middle of a run. The bench judges it by tracing every RAM access of that run against an order built independently from the requirements.

// File: rtl/galpat_pkg.sv
package galpat_pkg;

    typedef enum logic [2:0] {
        GP_IDLE,
        GP_FILL,
        GP_PROBE_WR,
        GP_RD_OTHER,
        GP_RD_PROBE,
        GP_RESTORE
    } gp_state_e;

endpackage

// File: rtl/galpat_addr.sv
module galpat_addr #(
    parameter int AW = 6,
    parameter int LW = AW + 1
) (
    input  logic [AW-1:0] base_i,
    input  logic [LW-1:0] off_i,
    output logic [AW-1:0] addr_o
);
    always_comb begin
        addr_o = base_i + off_i[AW-1:0];
    end
endmodule

// File: rtl/galpat_cmp.sv
module galpat_cmp #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic [AW-1:0] issue_addr_i,
    input  logic [DW-1:0] issue_exp_i,
    input  logic [DW-1:0] rdata_i,
    output logic          mismatch_o,
    output logic [AW-1:0] mis_addr_o
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [DW-1:0] exp;
    } pend_t;

    pend_t pend_d, pend_q;

    always_comb begin
        pend_d.valid = issue_i;
        pend_d.addr  = issue_addr_i;
        pend_d.exp   = issue_exp_i;
        mismatch_o   = pend_q.valid && (rdata_i != pend_q.exp);
        mis_addr_o   = pend_q.addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // R7: a mismatch is only raised for a read issued in the previous cycle
    p_cmp_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_o |-> $past(issue_i));
endmodule

// File: rtl/galpat_bist.sv
module galpat_bist
    import galpat_pkg::*;
#(
    parameter int              AW = 6,
    parameter int              DW = 8,
    parameter logic [DW-1:0]   BG = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base,
    input  logic [AW:0]   len,
    output logic [AW-1:0] ram_addr,
    output logic          ram_we,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr
);
    localparam int LW = AW + 1;

    typedef struct packed {
        gp_state_e     st;
        logic [AW-1:0] base;
        logic [LW-1:0] len;
        logic [LW-1:0] probe;
        logic [LW-1:0] other;
        logic          sweep;
        logic          done;
        logic          fail;
        logic [AW-1:0] faddr;
    } ctl_t;

    ctl_t q, d;

    logic [LW-1:0] off;
    logic          issue;
    logic [DW-1:0] exp_val;
    logic [DW-1:0] probe_val;
    logic [LW-1:0] nxt_other;
    logic          mismatch;
    logic [AW-1:0] mis_addr;
    logic [AW-1:0] addr_w;

    galpat_addr #(.AW(AW), .LW(LW)) u_addr (
        .base_i (q.base),
        .off_i  (off),
        .addr_o (addr_w)
    );

    galpat_cmp #(.AW(AW), .DW(DW)) u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_i      (issue),
        .issue_addr_i (addr_w),
        .issue_exp_i  (exp_val),
        .rdata_i      (ram_rdata),
        .mismatch_o   (mismatch),
        .mis_addr_o   (mis_addr)
    );

    always_comb begin
        d         = q;
        off       = '0;
        issue     = 1'b0;
        exp_val   = BG;
        ram_we    = 1'b0;
        ram_wdata = BG;
        probe_val = q.sweep ? BG : ~BG;
        nxt_other = q.other + LW'(1);
        if (nxt_other == q.probe) nxt_other = q.other + LW'(2);

        unique case (q.st)
            GP_IDLE: begin
                if (start) begin
                    d.base = base;
                    d.len  = len;
                    d.done = (len == '0);
                    d.fail = 1'b0;
                    d.other = '0;
                    if (len != '0) d.st = GP_FILL;
                end
            end
            GP_FILL: begin
                ram_we = 1'b1;
                off    = q.other;
                if (q.other == q.len - LW'(1)) begin
                    d.st    = GP_PROBE_WR;
                    d.probe = '0;
                    d.sweep = 1'b0;
                end else begin
                    d.other = q.other + LW'(1);
                end
            end
            GP_PROBE_WR: begin
                ram_we    = 1'b1;
                off       = q.probe;
                ram_wdata = probe_val;
                if (q.len == LW'(1)) begin
                    d.st = GP_RESTORE;
                end else begin
                    d.other = (q.probe == '0) ? LW'(1) : '0;
                    d.st    = GP_RD_OTHER;
                end
            end
            GP_RD_OTHER: begin
                off     = q.other;
                issue   = 1'b1;
                exp_val = BG;
                d.st    = GP_RD_PROBE;
            end
            GP_RD_PROBE: begin
                off     = q.probe;
                issue   = 1'b1;
                exp_val = probe_val;
                if (nxt_other >= q.len) begin
                    d.st = GP_RESTORE;
                end else begin
                    d.other = nxt_other;
                    d.st    = GP_RD_OTHER;
                end
            end
            GP_RESTORE: begin
                ram_we    = 1'b1;
                off       = q.probe;
                ram_wdata = BG;
                if (q.probe == q.len - LW'(1)) begin
                    if (q.sweep) begin
                        d.st   = GP_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.sweep = 1'b1;
                        d.probe = '0;
                        d.st    = GP_PROBE_WR;
                    end
                end else begin
                    d.probe = q.probe + LW'(1);
                    d.st    = GP_PROBE_WR;
                end
            end
            default: d.st = GP_IDLE;
        endcase

        // a mismatch wins over every other transition, including completion
        if (mismatch && q.st != GP_IDLE) begin
            d.st    = GP_IDLE;
            d.fail  = 1'b1;
            d.done  = 1'b0;
            d.faddr = mis_addr;
            ram_we  = 1'b0;
            issue   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= GP_IDLE;
        end else begin
            q <= d;
        end
    end

    assign ram_addr  = addr_w;
    assign busy      = (q.st != GP_IDLE);
    assign done      = q.done;
    assign fail      = q.fail;
    assign fail_addr = q.faddr;

    logic [AW-1:0] rel_addr;
    assign rel_addr = ram_addr - q.base;

    // R6: busy and done never coexist
    p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    // R11: every access stays inside the window
    p_addr_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, rel_addr} < q.len));
    // R7: the abort cycle leaves the block quiet
    p_quiet_after_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> (!busy && !ram_we));
    // R7: fail result holds until a new start
    p_fail_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> (fail && $stable(fail_addr)));
    // R9: empty window completes at once
    p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && len == '0) |=> (done && !busy));
    // R10: start during a run does not reload the window
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(q.base) && $stable(q.len));
endmodule

// File: tb/galpat_bist_tb.sv
module galpat_bist_tb;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam logic [DW-1:0] BG = '0;
    localparam int NCELL = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base = '0;
    logic [AW:0]   len = '0;
    logic [AW-1:0] ram_addr;
    logic          ram_we;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_rdata;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    galpat_bist #(.AW(AW), .DW(DW), .BG(BG)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .len(len),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr)
    );

    // RAM model with injectable faults
    logic [DW-1:0] mem [NCELL];
    logic          sa_en = 1'b0;
    logic [AW-1:0] sa_addr = '0;
    logic [DW-1:0] sa1_mask = '0;
    logic [DW-1:0] sa0_mask = '0;
    logic          cpl_en = 1'b0;
    logic [AW-1:0] cpl_agg = '0;
    logic [AW-1:0] cpl_vic = '0;
    logic          cor_en = 1'b0;
    int            cor_idx = 0;
    int            rd_cnt = 0;
    logic          rd_clr = 1'b0;
    logic [DW-1:0] rval;

    initial begin
        for (int i = 0; i < NCELL; i++) mem[i] = 8'h5A;
    end

    always @(posedge clk) begin
        if (rd_clr) rd_cnt <= 0;
        else if (busy && !ram_we) rd_cnt <= rd_cnt + 1;
        if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
            if (cpl_en && ram_addr == cpl_agg)
                mem[cpl_vic] <= mem[cpl_vic] ^ 8'h10;
        end else begin
            rval = mem[ram_addr];
            if (sa_en && ram_addr == sa_addr) rval = (rval | sa1_mask) & ~sa0_mask;
            if (cor_en && busy && rd_cnt == cor_idx) rval = rval ^ 8'h01;
            ram_rdata <= rval;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_faults();
        sa_en = 1'b0; cpl_en = 1'b0; cor_en = 1'b0;
    endtask

    task automatic pulse_start(input logic [AW-1:0] b, input logic [AW:0] l);
        @(negedge clk);
        base = b; len = l; start = 1'b1; rd_clr = 1'b1;
        @(negedge clk);
        start = 1'b0; rd_clr = 1'b0;
    endtask

    // trace state for access-order checks
    bit trace_bad;

    task automatic op(input logic [AW-1:0] b, input bit we, input int o,
                      input logic [DW-1:0] wd, input string req);
        if (!trace_bad) begin
            logic [AW-1:0] ea;
            bit ok;
            ea = b + AW'(o);
            ok = busy && (ram_we == we) && (ram_addr == ea) && (!we || ram_wdata == wd);
            chk(ok, req, we ? "write op addr/data" : "read op addr",
                {ram_we, ram_addr, ram_wdata}, {we, ea, we ? wd : ram_wdata});
            if (!ok) trace_bad = 1;
        end
        @(negedge clk);
    endtask

    // full access trace of a clean run; R2 R3 R4 R5 R6 R10 R11
    task automatic t_trace(input logic [AW-1:0] b, input int l, input bit mid_start);
        logic [DW-1:0] pv;
        bit sent;
        trace_bad = 0;
        sent = 0;
        pulse_start(b, (AW+1)'(l));
        chk(done == 0, "R6", "done cleared by start", done, 0);
        for (int i = 0; i < l; i++) op(b, 1, i, BG, "R2");
        for (int p = 0; p < 2; p++) begin
            pv = (p == 0) ? ~BG : BG;
            for (int t = 0; t < l; t++) begin
                op(b, 1, t, pv, "R3");
                for (int o = 0; o < l; o++) begin
                    if (o != t) begin
                        if (mid_start && !sent) begin
                            base = b + 6'd7; len = 7'd2; start = 1'b1; sent = 1;
                            op(b, 0, o, BG, "R10");
                            start = 1'b0;
                        end else begin
                            op(b, 0, o, BG, "R4");
                        end
                        op(b, 0, t, BG, "R4");
                    end
                end
                op(b, 1, t, BG, "R5");
            end
        end
        chk(!busy && done && !fail, "R6", "end state busy/done/fail",
            {busy, done, fail}, 3'b010);
        for (int i = 0; i < l; i++) begin
            logic [AW-1:0] a;
            a = b + AW'(i);
            chk(mem[a] == BG, "R5", "window cell holds background", mem[a], BG);
        end
        repeat (4) @(negedge clk);
        chk(done == 1, "R6", "done held while idle", done, 1);
    endtask

    // counts busy cycles of a run started now
    task automatic run_count(input logic [AW-1:0] b, input int l, output int cyc);
        cyc = 0;
        pulse_start(b, (AW+1)'(l));
        while (busy && cyc < 20000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic t_fault(input logic [AW-1:0] b, input int l, input logic [AW-1:0] exp_a,
                           input int exp_cyc, input string req);
        int cyc;
        run_count(b, l, cyc);
        chk(fail == 1, req, "fail raised", fail, 1);
        chk(done == 0, req, "done low on failure", done, 0);
        chk(fail_addr == exp_a, req, "fail_addr", fail_addr, exp_a);
        if (exp_cyc >= 0) chk(cyc == exp_cyc, req, "busy cycles before stop", cyc, exp_cyc);
        for (int k = 0; k < 4; k++) begin
            chk(!ram_we && !busy && fail && fail_addr == exp_a, "R7",
                "quiet and held after failure", {ram_we, busy, fail}, 3'b001);
            @(negedge clk);
        end
        clear_faults();
    endtask

    task automatic t_reset();
        chk(!busy && !done && !fail && !ram_we, "R1", "reset outputs",
            {busy, done, fail, ram_we}, 0);
    endtask

    task automatic t_empty();
        pulse_start(6'd20, '0);
        chk(done == 1 && busy == 0, "R9", "empty window done at once", {done, busy}, 2'b10);
        for (int k = 0; k < 3; k++) begin
            chk(!ram_we && !busy, "R9", "no access for empty window", {ram_we, busy}, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_cycles(input logic [AW-1:0] b, input int l);
        int cyc;
        run_count(b, l, cyc);
        chk(cyc == l + 4 * l * l, "R6", "clean run busy length", cyc, l + 4 * l * l);
        chk(done && !fail, "R6", "clean run result", {done, fail}, 2'b10);
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();

        t_trace(6'd10, 4, 1'b0);
        t_trace(6'd60, 5, 1'b0);         // R11 wrap past top address
        t_trace(6'd33, 1, 1'b0);         // single cell window
        t_trace(6'd2, 4, 1'b1);          // R10 start while busy
        t_empty();
        t_cycles(6'd0, 3);
        t_cycles(6'd40, 6);

        // R7 stuck-at-1 bit on a non-first cell
        sa_en = 1; sa_addr = 6'd14; sa1_mask = 8'h04; sa0_mask = 8'h00;
        t_fault(6'd12, 6, 6'd14, -1, "R7");
        // R7 stuck-at-0 bit caught on a probe read
        sa_en = 1; sa_addr = 6'd22; sa1_mask = 8'h00; sa0_mask = 8'h01;
        t_fault(6'd20, 5, 6'd22, -1, "R7");
        // R7 write to one cell flips another
        cpl_en = 1; cpl_agg = 6'd31; cpl_vic = 6'd33;
        t_fault(6'd30, 5, 6'd33, -1, "R7");
        // R7 exact latency: first read corrupted
        cor_en = 1; cor_idx = 0;
        t_fault(6'd50, 4, 6'd51, 4 + 3, "R7");
        // R8 last read of the run corrupted: failure beats completion
        cor_en = 1; cor_idx = 2 * 4 * 3 * 2 - 1;
        t_fault(6'd5, 4, 6'd8, 4 + 4 * 16, "R8");

        // new start clears a held failure
        t_cycles(6'd9, 2);
        chk(!fail, "R7", "fail cleared by new start", fail, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule